// File: doc/BRIEF.md
# Constant-Latency Interrupt Entry Sequencer

This block decides when a small 8-bit core with a four-clock instruction cycle accepts an interrupt, and it steps the core into the handler. Entry always takes the same number of instruction cycles. It does not matter whether the request lands in a one-cycle instruction or in the first cycle of a two-cycle instruction. The block makes its own phase count and samples every request once per instruction cycle, on the last clock of that cycle. The external pin is asynchronous, so it first passes through a flop synchroniser. The internal flags are already in the clock domain, so only their enables mask them.

Call the sampling cycle C. When a request is accepted in C, cycle C+1 is one of two things. If C ended its instruction, C+1 is a dead cycle with issue held off. If C was the first half of a two-cycle instruction, C+1 is that instruction's second half. Cycle C+2 is the vector fetch cycle. On its first clock the block issues three one-clock pulses:

- a push of the return address, which is the next-instruction address captured at the end of C+1;
- a load of the fixed vector address;
- a clear of the global enable.

The handler's first instruction issues in cycle C+3. Only the return address is preserved; no other register is saved.

Top module: `irq_entry_seq`

## Requirements
- R1: `phase` counts 0,1,2,3 on successive clocks and wraps. One instruction cycle is phases 0 to 3. Phase 3 is the last clock of a cycle.
- R2: The external pin passes through SYNC_STAGES flops before use, and `ext_en` masks it. Internal flag i counts only when `int_en[i]` is 1, and it needs no synchroniser. A request is sampled only on the clock edge that ends phase 3. A masked source never causes an entry.
- R3: A request is accepted only when `gie` is 1 at the sampling edge. A request held while `gie` is 0 stays pending and is accepted at the first sampling edge after `gie` becomes 1.
- R4: For a request accepted at the edge ending cycle C, `vec_load` rises on the first clock of cycle C+2. `issue_stall` is released on the first clock of cycle C+3. That is 4 and 8 clocks after the sampling edge, whatever instruction is in flight.
- R5: `issue_stall` is 1 for the whole vector fetch cycle. It is also 1 for a dead cycle C+1, which is inserted only when C was the last cycle of its instruction. If `insn_two` was 1 in a C that began an instruction, C+1 runs unstalled as that instruction's second cycle.
- R6: `push_req` is a one-clock pulse on the first clock of the vector fetch cycle. `push_addr` carries the `next_pc` value captured at the edge ending cycle C+1.
- R7: `vec_load` is a one-clock pulse, in the same clock as `push_req`. `vec_addr` carries the vector address parameter, 0x004 by default.
- R8: `gie_clr` is a one-clock pulse in the same clock as `vec_load`. It follows only a request accepted while `gie` was 1.
- R9: No new request is accepted during cycles C+1 and C+2, even if `gie` remains 1. Successive `vec_load` pulses are therefore at least 12 clocks apart.
- R10: While `rst_n` is 0, `phase` is 0 and every output pulse and the stall are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, four per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt line, level |
| ext_en | input | 1 | Enable for the external source |
| int_flag | input | N_SRC | Synchronous internal interrupt flags |
| int_en | input | N_SRC | Per-flag enables |
| gie | input | 1 | Global interrupt enable held by the core |
| insn_two | input | 1 | Instruction starting this cycle takes two cycles |
| next_pc | input | PC_W | Address of the next unexecuted instruction |
| phase | output | 2 | Current clock phase within the instruction cycle |
| issue_stall | output | 1 | Suppress instruction issue this cycle |
| push_req | output | 1 | Push return address onto the call stack |
| push_addr | output | PC_W | Return address to push |
| vec_load | output | 1 | Load program counter with the vector |
| vec_addr | output | PC_W | Vector address |
| gie_clr | output | 1 | Clear the global enable |

## Verification
Two functions can fall in the same cycle. The first is acceptance of a new request on a sampling edge. The second is the still-running entry sequence for an earlier one, because the core clears `gie` only after the vector fetch pulse. To provoke this, the bench keeps a request asserted and leaves `gie` set across entries. It then judges two things: no second entry may start inside the dead/tail or vector cycles, and consecutive vector loads must land exactly one full entry apart. A second overlap is the capture of the return address on the same edge where the core advances `next_pc`. A behavioural cycle model, running alongside, judges this on every clock under mixed one- and two-cycle instruction streams.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    // Sequencer states of the entry flow
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,   // normal execution, requests sampled at phase 3
        ST_DEAD = 2'd1,   // inserted empty cycle, issue suppressed
        ST_TAIL = 2'd2,   // second half of an interrupted two-cycle instruction
        ST_VEC  = 2'd3    // vector fetch cycle, issue suppressed
    } entry_st_e;

    localparam int unsigned PHASE_W = 2;

endpackage

// File: rtl/irq_phase_gen.sv
module irq_phase_gen #(
    parameter int unsigned PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            first_ph,
    output logic            last_ph
);
    localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase    = phase_q;
    assign first_ph = (phase_q == '0);
    assign last_ph  = (phase_q == PH_LAST);

    // Phase advances by exactly one per clock and wraps
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_q == PH_W'($past(phase_q) + 1'b1));

endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] st_d, st_q;

    always_comb begin
        st_d = STAGES'({st_q, pin_async});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_sync = st_q[STAGES-1];

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_chk
            // Each stage carries the previous stage one clock later
            assert_sync_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> st_q[i] == $past(st_q[i-1]));
        end
    endgenerate

endmodule

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
    parameter int unsigned N_SRC = 4
) (
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] enables,
    input  logic             ext_req,
    input  logic             ext_en,
    output logic             any_req
);
    logic [N_SRC-1:0] masked;

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_mask
            assign masked[i] = flags[i] & enables[i];
        end
    endgenerate

    assign any_req = (|masked) | (ext_req & ext_en);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned   N_SRC       = 4,
    parameter int unsigned   PC_W        = 13,
    parameter int unsigned   SYNC_STAGES = 2,
    parameter logic [PC_W-1:0] VECTOR    = 13'h004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             ext_en,
    input  logic [N_SRC-1:0] int_flag,
    input  logic [N_SRC-1:0] int_en,
    input  logic             gie,
    input  logic             insn_two,
    input  logic [PC_W-1:0]  next_pc,
    output logic [1:0]       phase,
    output logic             issue_stall,
    output logic             push_req,
    output logic [PC_W-1:0]  push_addr,
    output logic             vec_load,
    output logic [PC_W-1:0]  vec_addr,
    output logic             gie_clr
);
    typedef struct packed {
        entry_st_e       st;
        logic            second;  // current cycle is the second of a two-cycle instruction
        logic [PC_W-1:0] ret;     // captured return address
    } seq_t;

    logic [PHASE_W-1:0] ph;
    logic first_ph, last_ph;
    logic ext_sync, any_req;
    logic take, begins_two;
    seq_t d, q;

    irq_phase_gen #(.PH_W(PHASE_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(ph), .first_ph(first_ph), .last_ph(last_ph)
    );

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(ext_pin), .pin_sync(ext_sync)
    );

    irq_src_merge #(.N_SRC(N_SRC)) u_merge (
        .flags(int_flag), .enables(int_en), .ext_req(ext_sync), .ext_en(ext_en),
        .any_req(any_req)
    );

    always_comb begin
        d          = q;
        take       = 1'b0;
        begins_two = !q.second && insn_two;
        if (last_ph) begin
            unique case (q.st)
                ST_RUN: begin
                    take = gie && any_req;
                    if (take) begin
                        d.st     = begins_two ? ST_TAIL : ST_DEAD;
                        d.second = 1'b0;
                    end else begin
                        d.second = begins_two;
                    end
                end
                ST_DEAD, ST_TAIL: begin
                    d.st  = ST_VEC;
                    d.ret = next_pc;
                end
                ST_VEC: begin
                    d.st     = ST_RUN;
                    d.second = 1'b0;
                end
                default: d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_RUN, second: 1'b0, ret: '0};
        else        q <= d;
    end

    assign phase       = ph;
    assign issue_stall = (q.st == ST_DEAD) || (q.st == ST_VEC);
    assign push_req    = (q.st == ST_VEC) && first_ph;
    assign vec_load    = (q.st == ST_VEC) && first_ph;
    assign gie_clr     = (q.st == ST_VEC) && first_ph;
    assign push_addr   = q.ret;
    assign vec_addr    = VECTOR;

    // Vector load always follows a dead or tail cycle
    assert_vec_after_prep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> ($past(q.st) == ST_DEAD || $past(q.st) == ST_TAIL));

    // A stall always begins on a cycle boundary
    assert_stall_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue_stall) |-> ph == '0);

    // Return address does not move during the vector fetch cycle
    assert_ret_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_VEC && !first_ph) |-> $stable(q.ret));

    // Vector load lasts a single clock
    assert_vec_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> !vec_load);

    // Enable is cleared only for a request taken while enabled
    assert_gie_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |-> $past(gie, 5));

    // No new acceptance while an entry is in progress
    assert_no_retake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DEAD || q.st == ST_TAIL) |=> q.st != ST_RUN);

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC = 4;
    localparam int PC_W  = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_pin = 1'b0, ext_en = 1'b0;
    logic [N_SRC-1:0] int_flag = '0, int_en = '0;
    logic             gie = 1'b0, insn_two = 1'b0;
    logic [PC_W-1:0]  next_pc = '0;
    logic [1:0]       phase;
    logic             issue_stall, push_req, vec_load, gie_clr;
    logic [PC_W-1:0]  push_addr, vec_addr;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_en(ext_en),
        .int_flag(int_flag), .int_en(int_en), .gie(gie), .insn_two(insn_two),
        .next_pc(next_pc), .phase(phase), .issue_stall(issue_stall),
        .push_req(push_req), .push_addr(push_addr), .vec_load(vec_load),
        .vec_addr(vec_addr), .gie_clr(gie_clr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    bit done = 0;
    bit auto_clr = 1;
    int two_mode = 0;
    logic [7:0] lfsr = 8'h5a;

    // behavioural model state
    int m_ph = 0, m_mode = 0;   // mode: 0 run, 1 dead, 2 tail, 3 vector
    bit m_second = 0, m_s0 = 0, m_s1 = 0;
    int m_ret = 0;
    longint clk_n = 0, take_clk = -100, last_vec = -100;
    int vec_count = 0;
    bit prev_stall = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced at each rising edge from bench-driven inputs
    always @(posedge clk) begin
        bit req, first;
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_second = 0; m_ret = 0; m_s0 = 0; m_s1 = 0;
        end else begin
            req = (m_s1 && ext_en) || ((int_flag & int_en) != '0);
            if (m_ph == 3) begin
                case (m_mode)
                    0: begin
                        first = !m_second && insn_two;
                        if (gie && req) begin
                            m_mode = first ? 2 : 1;
                            m_second = 0;
                            take_clk = clk_n;
                        end else m_second = first;
                    end
                    1, 2: begin m_mode = 3; m_ret = int'(next_pc); end
                    default: begin m_mode = 0; m_second = 0; end
                endcase
            end
            m_ph = (m_ph + 1) % 4;
            m_s1 = m_s0;
            m_s0 = ext_pin;
        end
        clk_n++;
    end

    // per-clock comparison away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                bit es, ef;
                es = (m_mode == 1) || (m_mode == 3);
                ef = (m_mode == 3) && (m_ph == 0);
                chk(int'(phase) == m_ph, "R1 phase", phase, m_ph);
                chk(issue_stall == es, "R5 issue_stall", issue_stall, es);
                chk(push_req == ef, "R6 push_req", push_req, ef);
                chk(vec_load == ef, "R7 vec_load", vec_load, ef);
                chk(gie_clr == ef, "R8 gie_clr", gie_clr, ef);
                if (ef) begin
                    chk(int'(push_addr) == m_ret, "R6 push_addr", push_addr, m_ret);
                    chk(vec_addr == 13'h004, "R7 vec_addr", vec_addr, 4);
                end
                if (vec_load) begin
                    vec_count++;
                    chk(clk_n - take_clk == 5, "R4 vector latency", clk_n - take_clk, 5);
                    if (last_vec >= 0)
                        chk(clk_n - last_vec >= 12, "R9 entry spacing", clk_n - last_vec, 12);
                    last_vec = clk_n;
                end
                if (prev_stall && !issue_stall && take_clk >= 0 && clk_n - take_clk < 12)
                    chk(clk_n - take_clk == 9, "R4 handler start", clk_n - take_clk, 9);
                prev_stall = issue_stall;
            end
        end
    end

    // core-side driver: instruction stream, pc, enable clearing
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (gie_clr && auto_clr) gie = 1'b0;
                if (phase == 2'd0) begin
                    next_pc = next_pc + 13'd3;
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    case (two_mode)
                        0: insn_two = 1'b0;
                        1: insn_two = 1'b1;
                        default: insn_two = lfsr[0];
                    endcase
                end
            end
        end
    end

    task automatic at_edge();
        @(posedge clk); #2;
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) at_edge();
    endtask

    task automatic wait_vec(input int limit, output bit seen);
        int start = vec_count;
        seen = 0;
        for (int i = 0; i < limit && !seen; i++) begin
            at_edge();
            if (vec_count != start) seen = 1;
        end
    endtask

    initial begin
        bit seen;
        int c0;
        // R10: reset state
        #(CLK_PERIOD*3 + 2);
        chk(phase == 2'd0, "R10 phase in reset", phase, 0);
        chk({issue_stall, push_req, vec_load, gie_clr} == 4'b0, "R10 outputs in reset",
            {issue_stall, push_req, vec_load, gie_clr}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: masked sources never enter
        at_edge();
        gie = 1'b1; int_flag = 4'b0010; int_en = 4'b1101; ext_pin = 1'b1; ext_en = 1'b0;
        c0 = vec_count;
        wait_clks(60);
        chk(vec_count == c0, "R2 masked sources", vec_count - c0, 0);
        ext_pin = 1'b0; int_flag = '0;

        // R3: pending while disabled, taken once enabled
        gie = 1'b0; int_en = 4'b0010; int_flag = 4'b0010;
        c0 = vec_count;
        wait_clks(40);
        chk(vec_count == c0, "R3 held while disabled", vec_count - c0, 0);
        gie = 1'b1;
        wait_vec(20, seen);
        chk(seen, "R3 taken after enable", seen, 1);
        int_flag = '0;
        wait_clks(16);

        // R5: two-cycle stream and mixed stream with internal sources
        for (int mode = 1; mode <= 2; mode++) begin
            two_mode = mode;
            for (int k = 0; k < 6; k++) begin
                wait_clks(k + 3);
                gie = 1'b1; int_en = 4'b1111; int_flag = 4'(1 << (k % 4));
                wait_vec(40, seen);
                chk(seen, "R5 entry under instruction mix", seen, 1);
                int_flag = '0;
                wait_clks(12);
            end
        end

        // R2: external pin through synchroniser, varied offsets
        two_mode = 2; int_en = '0; ext_en = 1'b1;
        for (int off = 0; off < 8; off++) begin
            wait_clks(off + 5);
            gie = 1'b1; ext_pin = 1'b1;
            wait_vec(40, seen);
            chk(seen, "R2 external entry", seen, 1);
            ext_pin = 1'b0;
            wait_clks(12);
        end
        // short pulse sampled or not; model decides
        gie = 1'b1; ext_pin = 1'b1; at_edge(); ext_pin = 1'b0;
        wait_clks(30);

        // R9: request held with enable left set across entries
        auto_clr = 0; ext_en = 1'b0; int_en = 4'b0001; int_flag = 4'b0001; gie = 1'b1;
        c0 = vec_count;
        wait_clks(60);
        chk(vec_count - c0 >= 3, "R9 repeated entries", vec_count - c0, 3);
        int_flag = '0; auto_clr = 1;
        wait_clks(20);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule